// File: doc/BRIEF.md
# Oversampling Serial Receiver with Flagged Character Queue

This block turns an asynchronous serial line into a queue of received characters. A 16x baud enable pulse paces it. The line is first synchronised. A falling edge is confirmed at the middle of the start bit, and each later bit is sampled at the middle of its period. Characters are 8 bits, or 9 bits when the wide mode is selected. In 8-bit mode an optional parity bit follows the data.

Each finished character goes into a four-entry queue. Its own parity-error and framing-error marks travel with it, so the marks shown at the head always belong to the character shown at the head. The host takes characters through a valid/ready read port. The rules of that port are as follows:
- `rd_valid` is high whenever the queue holds a character.
- The head, with its marks, stays stable until a cycle in which `rd_valid` and `rd_ready` are both high.
- That cycle removes the head. The next entry appears on the following cycle.
- `rd_ready` may be held high at any time. It has no effect while the queue is empty.

If a character completes while the queue is full and no pop happens in that cycle, the block raises a sticky overrun flag. It then stops reception until software clears the flag. An interrupt output compares the queue fill against a level picked by a 2-bit select.

Top module: `uart_rx_engine`

## Requirements
- R1: In 8-bit mode a frame is one low start bit, 8 data bits least significant first, an optional parity bit and one stop bit. The character appears on `rd_data[7:0]` with `rd_data[8]` = 0.
- R2: With `cfg_nine_bit` = 1 a frame carries 9 data bits, least significant first, on `rd_data[8:0]`. No parity bit is expected, whatever `cfg_parity` holds.
- R3: `cfg_parity` selects the parity mode: 01 is even, 10 is odd, and 00 or 11 means no parity bit. `rd_perr` is 1 for a character whose parity bit does not match its 8 data bits.
- R4: A stop bit sampled low sets `rd_ferr` for that character, and the character is still queued. After that, the receiver waits for the line to go high before it looks for a new start bit.
- R5: A low level that is gone at the start-bit confirmation point produces no character. The confirmation point is 8 ticks after the edge is seen.
- R6: The queue holds 4 characters in arrival order. While `rd_valid` = 1 the head shows its data and its own marks. A cycle with `rd_valid` and `rd_ready` both high removes the head.
- R7: `rd_ready` while the queue is empty has no effect.
- R8: A character that completes while the queue is full, with no pop in that cycle, is discarded and sets `ovr_err`. The flag stays set until an `ovr_clr` pulse, and a new overrun in the same cycle wins over the clear. While the flag is set, no new character is received.
- R9: `rx_irq` is high while the fill is at least the selected level. The levels are: 00 or 01 means 1 character, 10 means 3 characters, and 11 means 4 characters.
- R10: After reset the queue is empty, and `ovr_err` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_serial | input | 1 | Serial line, idle high |
| cfg_nine_bit | input | 1 | 1 selects 9-bit characters |
| cfg_parity | input | 2 | 00/11 none, 01 even, 10 odd (8-bit mode only) |
| cfg_irq_sel | input | 2 | Interrupt fill level select |
| rd_valid | output | 1 | Queue head holds a character |
| rd_ready | input | 1 | Host accepts the head |
| rd_data | output | 9 | Head character |
| rd_perr | output | 1 | Parity mark of the head character |
| rd_ferr | output | 1 | Framing mark of the head character |
| ovr_err | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Pulse that clears the overrun flag |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The stop bit is sampled on the tick at its middle. That same edge registers the completed character, and the next edge writes it into the queue. `rd_valid`, the head fields and `rx_irq` are therefore correct two edges after that tick, and `ovr_err` is set on the same edge that would have written the entry. The bench waits until the stop bit and a whole idle bit have passed, which is many cycles beyond those two edges, and then samples at a falling edge. For a pop it raises `rd_ready` at one falling edge and compares the new head at the next falling edge, one rising edge later.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int CHAR_W = 9;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_char_t;

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_line,
  input  logic       nine_bit,
  input  logic [1:0] parity_mode,
  input  logic       hold,
  output logic       char_valid,
  output rx_char_t   char_out
);

  localparam int CW      = $clog2(OVERSAMPLE);
  localparam int MID_CNT = OVERSAMPLE / 2 - 1;
  localparam int END_CNT = OVERSAMPLE - 1;

  logic [1:0]        sync_q;
  logic              rx_s;
  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [3:0]        bit_idx;
  logic [CHAR_W-1:0] shreg;
  logic              perr_q;
  logic              par_on;
  logic [3:0]        last_idx;
  logic              at_mid;
  logic              at_end;

  assign rx_s     = sync_q[1];
  assign par_on   = !nine_bit && (parity_mode == PAR_EVEN || parity_mode == PAR_ODD);
  assign last_idx = nine_bit ? 4'd8 : 4'd7;
  assign at_mid   = (cnt == CW'(MID_CNT));
  assign at_end   = (cnt == CW'(END_CNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], rx_line};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      perr_q     <= 1'b0;
      char_valid <= 1'b0;
      char_out   <= '0;
    end else begin
      char_valid <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            if (!hold && !rx_s) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (at_mid) begin
              cnt <= '0;
              if (!rx_s) begin
                state   <= RX_DATA;
                bit_idx <= '0;
                shreg   <= '0;
                perr_q  <= 1'b0;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (at_end) begin
              cnt            <= '0;
              shreg[bit_idx] <= rx_s;
              if (bit_idx == last_idx) begin
                state <= par_on ? RX_PARITY : RX_STOP;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PARITY: begin
            if (at_end) begin
              cnt    <= '0;
              perr_q <= (^shreg[7:0]) ^ rx_s ^ (parity_mode == PAR_ODD);
              state  <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (at_end) begin
              cnt           <= '0;
              char_valid    <= 1'b1;
              char_out.data <= shreg;
              char_out.perr <= perr_q;
              char_out.ferr <= !rx_s;
              state         <= rx_s ? RX_IDLE : RX_WAIT_HIGH;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_WAIT_HIGH: begin
            if (rx_s) begin
              state <= RX_IDLE;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_valid,
  input  rx_char_t                   push_data,
  input  logic                       pop_req,
  output rx_char_t                   head,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       empty,
  output logic                       overrun
);

  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          full;
  logic          accept;
  logic          pop_eff;
  rx_char_t      slot_data [DEPTH];

  assign full    = (fill == CNTW'(DEPTH));
  assign empty   = (fill == '0);
  assign pop_eff = pop_req && !empty;
  assign accept  = push_valid && (!full || pop_eff);
  assign overrun = push_valid && full && !pop_eff;
  assign head    = slot_data[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rx_char_t slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (accept && wr_ptr == AW'(i)) begin
        slot_q <= push_data;
      end
    end
    assign slot_data[i] = slot_q;
  end

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (accept) begin
        wr_ptr <= next_ptr(wr_ptr);
      end
      if (pop_eff) begin
        rd_ptr <= next_ptr(rd_ptr);
      end
      if (accept && !pop_eff) begin
        fill <= fill + 1'b1;
      end else if (pop_eff && !accept) begin
        fill <= fill - 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(DEPTH+1)-1:0] fill,
  input  logic                       overrun_evt,
  input  logic                       ovr_clr,
  input  logic [1:0]                 irq_sel,
  output logic                       irq,
  output logic                       ovr
);

  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int LVL3 = (DEPTH < 3) ? DEPTH : 3;

  logic [CNTW-1:0] level;

  always_comb begin
    unique case (irq_sel)
      2'b10:   level = CNTW'(LVL3);
      2'b11:   level = CNTW'(DEPTH);
      default: level = CNTW'(1);
    endcase
  end

  assign irq = (fill >= level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr <= 1'b0;
    end else if (overrun_evt) begin
      ovr <= 1'b1;
    end else if (ovr_clr) begin
      ovr <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rx_serial,
  input  logic       cfg_nine_bit,
  input  logic [1:0] cfg_parity,
  input  logic [1:0] cfg_irq_sel,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [8:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       ovr_err,
  input  logic       ovr_clr,
  output logic       rx_irq
);

  localparam int CNTW = $clog2(FIFO_DEPTH + 1);

  logic            char_valid;
  rx_char_t        char_new;
  rx_char_t        head;
  logic [CNTW-1:0] fill_cnt;
  logic            q_empty;
  logic            overrun_evt;

  uart_rx_sampler #(.OVERSAMPLE(OVERSAMPLE)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (baud_tick),
    .rx_line    (rx_serial),
    .nine_bit   (cfg_nine_bit),
    .parity_mode(cfg_parity),
    .hold       (ovr_err),
    .char_valid (char_valid),
    .char_out   (char_new)
  );

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_valid(char_valid),
    .push_data (char_new),
    .pop_req   (rd_ready),
    .head      (head),
    .fill      (fill_cnt),
    .empty     (q_empty),
    .overrun   (overrun_evt)
  );

  uart_rx_status #(.DEPTH(FIFO_DEPTH)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill       (fill_cnt),
    .overrun_evt(overrun_evt),
    .ovr_clr    (ovr_clr),
    .irq_sel    (cfg_irq_sel),
    .irq        (rx_irq),
    .ovr        (ovr_err)
  );

  assign rd_valid = !q_empty;
  assign rd_data  = head.data;
  assign rd_perr  = head.perr;
  assign rd_ferr  = head.ferr;

endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rd_valid,
  input logic                       rd_ready,
  input logic                       ovr_err,
  input logic                       ovr_clr,
  input logic                       rx_irq,
  input logic [1:0]                 cfg_irq_sel,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic                       char_valid
);

  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= DEPTH);

  assert_pop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !char_valid |=> fill == $past(fill) - 1'b1);

  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid && rd_ready && !char_valid |=> !rd_valid);

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err && !ovr_clr |=> ovr_err);

  assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(char_valid) && $past(fill) == DEPTH);

  assert_ovr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |-> !char_valid);

  assert_irq_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_irq_sel == 2'b11 && fill != DEPTH |-> !rx_irq);

  assert_irq_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !rx_irq);

endmodule

bind uart_rx_engine uart_rx_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .ovr_err    (ovr_err),
  .ovr_clr    (ovr_clr),
  .rx_irq     (rx_irq),
  .cfg_irq_sel(cfg_irq_sel),
  .fill       (fill_cnt),
  .char_valid (char_valid)
);

// File: tb/tb_uart_rx_engine.sv
module tb_uart_rx_engine;

  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;
  localparam int WATCHDOG = 190000;

  // {nine, parity[1:0], bad_par, bad_stop, din[8:0], exp_data[8:0], exp_perr, exp_ferr}
  localparam int NVEC = 10;
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 2'b00, 1'b0, 1'b0, 9'h0A5, 9'h0A5, 1'b0, 1'b0},
    {1'b0, 2'b01, 1'b0, 1'b0, 9'h03C, 9'h03C, 1'b0, 1'b0},
    {1'b0, 2'b01, 1'b1, 1'b0, 9'h03C, 9'h03C, 1'b1, 1'b0},
    {1'b0, 2'b10, 1'b0, 1'b0, 9'h081, 9'h081, 1'b0, 1'b0},
    {1'b0, 2'b10, 1'b1, 1'b0, 9'h007, 9'h007, 1'b1, 1'b0},
    {1'b1, 2'b00, 1'b0, 1'b0, 9'h155, 9'h155, 1'b0, 1'b0},
    {1'b1, 2'b01, 1'b0, 1'b0, 9'h1C3, 9'h1C3, 1'b0, 1'b0},
    {1'b0, 2'b00, 1'b0, 1'b1, 9'h05A, 9'h05A, 1'b0, 1'b1},
    {1'b1, 2'b00, 1'b0, 1'b1, 9'h0AA, 9'h0AA, 1'b0, 1'b1},
    {1'b0, 2'b11, 1'b0, 1'b0, 9'h0F0, 9'h0F0, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rx_serial = 1'b1;
  logic       cfg_nine_bit = 1'b0;
  logic [1:0] cfg_parity = 2'b00;
  logic [1:0] cfg_irq_sel = 2'b00;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [8:0] rd_data;
  logic       rd_perr;
  logic       rd_ferr;
  logic       ovr_err;
  logic       ovr_clr = 1'b0;
  logic       rx_irq;

  int n_cmp = 0;
  int n_mis = 0;

  always #4 clk = ~clk;

  uart_rx_engine dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .baud_tick   (baud_tick),
    .rx_serial   (rx_serial),
    .cfg_nine_bit(cfg_nine_bit),
    .cfg_parity  (cfg_parity),
    .cfg_irq_sel (cfg_irq_sel),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_data     (rd_data),
    .rd_perr     (rd_perr),
    .rd_ferr     (rd_ferr),
    .ovr_err     (ovr_err),
    .ovr_clr     (ovr_clr),
    .rx_irq      (rx_irq)
  );

  initial begin
    int tc;
    tc = 0;
    forever begin
      @(negedge clk);
      tc = tc + 1;
      baud_tick = (tc % TICK_DIV == 0);
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bit_wait();
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic nine, input logic [1:0] par,
                            input logic [8:0] d, input logic bad_par,
                            input logic bad_stop);
    int nbits;
    logic pbit;
    nbits = nine ? 9 : 8;
    @(negedge clk);
    rx_serial = 1'b0;
    bit_wait();
    for (int i = 0; i < nbits; i++) begin
      rx_serial = d[i];
      bit_wait();
    end
    if (!nine && (par == 2'b01 || par == 2'b10)) begin
      pbit = (^d[7:0]) ^ (par == 2'b10) ^ bad_par;
      rx_serial = pbit;
      bit_wait();
    end
    rx_serial = !bad_stop;
    bit_wait();
    rx_serial = 1'b1;
    bit_wait();
  endtask

  task automatic send8(input logic [7:0] d);
    send_frame(1'b0, 2'b00, {1'b0, d}, 1'b0, 1'b0);
  endtask

  task automatic pop_one();
    @(negedge clk);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic run_all();
    // R10: state right after reset
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R10", "rd_valid after reset", rd_valid, 0);
    check("R10", "ovr_err after reset", ovr_err, 0);
    check("R10", "rx_irq after reset", rx_irq, 0);

    // R7: pop on empty queue, then a frame must still land as head
    pop_one();
    check("R7", "rd_valid after empty pop", rd_valid, 0);

    // table walk: R1 R2 R3 R4 R6 R9(sel 00)
    for (int v = 0; v < NVEC; v++) begin
      logic [24:0] e;
      e = VEC[v];
      cfg_nine_bit = e[24];
      cfg_parity   = e[23:22];
      send_frame(e[24], e[23:22], e[19:11], e[21], e[20]);
      check("R6", "rd_valid after frame", rd_valid, 1);
      check(e[24] ? "R2" : "R1", "rd_data", rd_data, e[10:2]);
      check("R3", "rd_perr", rd_perr, e[1]);
      check("R4", "rd_ferr", rd_ferr, e[0]);
      check("R9", "rx_irq sel00 one char", rx_irq, 1);
      pop_one();
      check("R6", "rd_valid after pop", rd_valid, 0);
    end
    cfg_nine_bit = 1'b0;
    cfg_parity   = 2'b00;

    // R5: short low glitch is not a start bit
    @(negedge clk);
    rx_serial = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    rx_serial = 1'b1;
    bit_wait();
    bit_wait();
    check("R5", "rd_valid after glitch", rd_valid, 0);

    // R6 ordering with mixed marks, R9 sel 11 level
    cfg_irq_sel = 2'b11;
    cfg_parity  = 2'b01;
    send_frame(1'b0, 2'b01, 9'h011, 1'b1, 1'b0);
    send_frame(1'b0, 2'b01, 9'h022, 1'b0, 1'b1);
    send_frame(1'b0, 2'b01, 9'h033, 1'b0, 1'b0);
    check("R9", "rx_irq sel11 at 3", rx_irq, 0);
    send_frame(1'b0, 2'b01, 9'h044, 1'b1, 1'b1);
    check("R9", "rx_irq sel11 at 4", rx_irq, 1);
    check("R8", "no overrun at exactly full", ovr_err, 0);

    // R8: fifth character overruns, sixth ignored
    send_frame(1'b0, 2'b01, 9'h055, 1'b0, 1'b0);
    check("R8", "ovr_err after fifth", ovr_err, 1);
    send_frame(1'b0, 2'b01, 9'h066, 1'b0, 1'b0);
    check("R8", "ovr_err stays set", ovr_err, 1);

    // R9 sel 10 while draining, R6 order and per-entry marks
    cfg_irq_sel = 2'b10;
    @(negedge clk);
    check("R9", "rx_irq sel10 at 4", rx_irq, 1);
    check("R6", "head0 data", rd_data, 9'h011);
    check("R6", "head0 perr", rd_perr, 1);
    check("R6", "head0 ferr", rd_ferr, 0);
    pop_one();
    check("R9", "rx_irq sel10 at 3", rx_irq, 1);
    check("R6", "head1 data", rd_data, 9'h022);
    check("R6", "head1 perr", rd_perr, 0);
    check("R6", "head1 ferr", rd_ferr, 1);
    pop_one();
    check("R9", "rx_irq sel10 at 2", rx_irq, 0);
    cfg_irq_sel = 2'b01;
    @(negedge clk);
    check("R9", "rx_irq sel01 at 2", rx_irq, 1);
    check("R6", "head2 data", rd_data, 9'h033);
    check("R6", "head2 perr", rd_perr, 0);
    pop_one();
    check("R6", "head3 data", rd_data, 9'h044);
    check("R6", "head3 marks", {rd_perr, rd_ferr}, 2'b11);
    pop_one();
    check("R8", "discarded chars absent", rd_valid, 0);
    check("R9", "rx_irq empty", rx_irq, 0);

    // R8: clear, reception resumes
    @(negedge clk);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    check("R8", "ovr_err after clear", ovr_err, 0);
    cfg_parity = 2'b00;
    send8(8'hC7);
    check("R8", "rd_valid after resume", rd_valid, 1);
    check("R8", "data after resume", rd_data, 9'h0C7);

    // R10: reset with data queued empties it
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "rd_valid after mid-run reset", rd_valid, 0);
    check("R10", "rx_irq after mid-run reset", rx_irq, 0);
  endtask

  initial begin
    fork
      begin
        run_all();
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_mis++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

endmodule